// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the software-visible register front end of a simple LCD panel controller. It decodes a small word-addressed bus into six locations: control, three timing words, status and subpanel. It holds the panel's mode, enable, interrupt-mask and resolution settings, and presents the decoded settings to the rest of the controller as plain configuration outputs.

The frame sequencer reports its progress through three sticky status flags: frame done, sync error and palette loaded. Each flag has its own single-cycle set pulse and its own clear pulse. Software can read the flags but cannot write them. A single level interrupt is formed from the flags and two mask bits. Sync error always raises the interrupt and cannot be masked.

Whenever a control write flips the enable bit, a small two-state machine (states `EN_OFF` and `EN_ON`, transitions START and STOP) issues a one-cycle start or stop pulse to the sequencer. Pixel fetch, palette decoding and panel timing generation are handled elsewhere.

Top module: `lcd_regif`

## Requirements
- R1: After reset, all stored fields, flags, width and height are zero and irq is low. Reads then return: control 0xFE000C34, timing 0 0x000003FF, timing 1 0x000003FF, timing 2 0xFC000000, status 0 and subpanel 0.
- R2: The control register is at byte offset 0x00. A write sets enable from bit 0, mono from bit 1, the two interrupt-mask bits from bits 4:3, TFT mode from bit 7 and the palette-load mode from bits 21:20, and keeps bits under mask 0x01CFF300. A read returns all of these with TFT also mirrored at bit 23, ORed with 0xFE000C34.
- R3: Timing word 0 is at offset 0x04. Write bits 9:0 set cfg_width to that value plus one, and bits 31:10 are stored. A read returns bits 31:10 as stored and bits 9:0 as (cfg_width-1) modulo 1024, ORed with 0x0000000F.
- R4: Timing word 1 is at offset 0x08. Write bits 9:0 set cfg_height to that value plus one, and bits 31:10 are stored. A read returns bits 31:10 and (cfg_height-1) modulo 1024 in bits 9:0.
- R5: Timing word 2 is at offset 0x0C. It stores all 32 bits and reads back ORed with 0xFC000000.
- R6: The subpanel register is at offset 0x14. It stores the written value ANDed with 0xA1FFFFFF.
- R7: The status register is at offset 0x10: frame done at bit 0, sync error at bit 2, palette loaded at bit 6. Each flag is set by its set pulse and cleared by its clear pulse, and set wins when both arrive in the same cycle. Flags are visible the cycle after the pulse. Bus writes to status have no effect.
- R8: irq is high when frame done is set and mask bit 0 (control bit 3) is 1, or when palette loaded is set and mask bit 1 (control bit 4) is 1. Otherwise it is low unless R9 applies.
- R9: irq is high whenever sync error is set, whatever the mask bits are.
- R10: A control write that changes the enable bit produces a one-cycle pulse in the cycle after the write: seq_start when enable goes 0 to 1, seq_stop when it goes 1 to 0. A control write that leaves enable unchanged produces no pulse, and cfg_enable changes only on control writes.
- R11: An access to an offset with nonzero bits 1:0, or to a word index of 6 or more, reads as zero and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write when 1 (with bus_sel) |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fl_set_frame | input | 1 | Set pulse for frame done |
| fl_set_sync | input | 1 | Set pulse for sync error |
| fl_set_pal | input | 1 | Set pulse for palette loaded |
| fl_clr_frame | input | 1 | Clear pulse for frame done |
| fl_clr_sync | input | 1 | Clear pulse for sync error |
| fl_clr_pal | input | 1 | Clear pulse for palette loaded |
| irq | output | 1 | Combined level interrupt |
| seq_start | output | 1 | One-cycle start request to the sequencer |
| seq_stop | output | 1 | One-cycle stop request to the sequencer |
| cfg_enable | output | 1 | Controller enabled |
| cfg_mono | output | 1 | Monochrome mode |
| cfg_tft | output | 1 | TFT panel mode |
| cfg_plm | output | 2 | Palette-load mode |
| cfg_width | output | RES_W+1 | Active width in pixels (0 after reset) |
| cfg_height | output | RES_W+1 | Active height in lines (0 after reset) |

## Verification
On every cycle, the assertions check the following. A sync-error pulse always raises irq on the next cycle. Start and stop pulses never overlap, and each matches the direction of the enable change. Enable moves only on a control write. Misaligned addresses read as zero. A status write with no sequencer activity leaves irq steady. A timing-0 write yields the written width plus one. Some checks need a chosen history, and only the bench's scenarios show them: the exact read-back values with their forced-one bits, the set-over-clear priority, masking of frame done and palette loaded, the absence of a pulse on a same-value enable write, and the untouched registers after unmapped writes.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;

    localparam int DW     = 32;
    localparam int NREGS  = 6;
    localparam int NFLAGS = 3;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_TIM0 = 3'd1,
        REG_TIM1 = 3'd2,
        REG_TIM2 = 3'd3,
        REG_STAT = 3'd4,
        REG_SUBP = 3'd5,
        REG_NONE = 3'd7
    } reg_sel_e;

    typedef enum logic {
        EN_OFF = 1'b0,
        EN_ON  = 1'b1
    } en_state_e;

    // flag indices inside the flag vector
    localparam int FLG_FRAME = 0;
    localparam int FLG_SYNC  = 1;
    localparam int FLG_PAL   = 2;

    // status bit positions seen by software
    localparam int STAT_FRAME_BIT = 0;
    localparam int STAT_SYNC_BIT  = 2;
    localparam int STAT_PAL_BIT   = 6;

    localparam logic [DW-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
    localparam logic [DW-1:0] CTRL_RD_ONES   = 32'hFE00_0C34;
    localparam logic [DW-1:0] TIM0_RD_ONES   = 32'h0000_000F;
    localparam logic [DW-1:0] TIM2_RD_ONES   = 32'hFC00_0000;
    localparam logic [DW-1:0] SUBP_MASK      = 32'hA1FF_FFFF;

endpackage

// File: rtl/lcd_regif_decode.sv
module lcd_regif_decode
    import lcd_regif_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          region,
    output logic [NREGS-1:0]  wr_strobe
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    assign word_idx = addr[ADDR_W-1:2];

    always_comb begin
        if (addr[1:0] != 2'b00 || word_idx >= IDX_W'(NREGS)) begin
            region = REG_NONE;
        end else begin
            region = reg_sel_e'(word_idx[2:0]);
        end
    end

    for (genvar i = 0; i < NREGS; i++) begin : g_strobe
        assign wr_strobe[i] = sel && we && (region == reg_sel_e'(i));
    end

endmodule

// File: rtl/lcd_regif_flags.sv
module lcd_regif_flags
    import lcd_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set_p,
    input  logic [NFLAGS-1:0] clr_p,
    input  logic [1:0]        int_mask,
    output logic [NFLAGS-1:0] flags,
    output logic              irq
);
    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set_p[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_p[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

    // sync error is never masked
    always_comb begin
        irq = flags[FLG_SYNC]
            | (flags[FLG_FRAME] & int_mask[0])
            | (flags[FLG_PAL]   & int_mask[1]);
    end

endmodule

// File: rtl/lcd_regif_enfsm.sv
module lcd_regif_enfsm
    import lcd_regif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic new_enable,
    output logic enabled,
    output logic start_p,
    output logic stop_p
);
    en_state_e state_q, state_d;

    // next-state: START (OFF->ON) and STOP (ON->OFF) on a control write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_OFF: if (ctrl_wr &&  new_enable) state_d = EN_ON;
            EN_ON:  if (ctrl_wr && !new_enable) state_d = EN_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EN_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_p <= 1'b0;
            stop_p  <= 1'b0;
        end else begin
            start_p <= (state_q == EN_OFF) && (state_d == EN_ON);
            stop_p  <= (state_q == EN_ON)  && (state_d == EN_OFF);
        end
    end

    assign enabled = (state_q == EN_ON);

endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
    import lcd_regif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int RES_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fl_set_frame,
    input  logic              fl_set_sync,
    input  logic              fl_set_pal,
    input  logic              fl_clr_frame,
    input  logic              fl_clr_sync,
    input  logic              fl_clr_pal,
    output logic              irq,
    output logic              seq_start,
    output logic              seq_stop,
    output logic              cfg_enable,
    output logic              cfg_mono,
    output logic              cfg_tft,
    output logic [1:0]        cfg_plm,
    output logic [RES_W:0]    cfg_width,
    output logic [RES_W:0]    cfg_height
);
    localparam int HI_W = DW - RES_W;

    reg_sel_e          region;
    logic [NREGS-1:0]  wr_strobe;

    logic [1:0]        int_mask_q;
    logic              mono_q, tft_q;
    logic [1:0]        plm_q;
    logic [DW-1:0]     ctrl_keep_q;
    logic [HI_W-1:0]   tim0_hi_q, tim1_hi_q;
    logic [RES_W:0]    width_q, height_q;
    logic [DW-1:0]     tim2_q, subp_q;
    logic [NFLAGS-1:0] flags;
    logic [NFLAGS-1:0] set_vec, clr_vec;
    logic [RES_W:0]    width_m1, height_m1;

    lcd_regif_decode #(.ADDR_W(ADDR_W)) decode_i (
        .sel       (bus_sel),
        .we        (bus_we),
        .addr      (bus_addr),
        .region    (region),
        .wr_strobe (wr_strobe)
    );

    lcd_regif_enfsm enfsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_strobe[REG_CTRL]),
        .new_enable (bus_wdata[0]),
        .enabled    (cfg_enable),
        .start_p    (seq_start),
        .stop_p     (seq_stop)
    );

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        set_vec[FLG_FRAME] = fl_set_frame;
        set_vec[FLG_SYNC]  = fl_set_sync;
        set_vec[FLG_PAL]   = fl_set_pal;
        clr_vec[FLG_FRAME] = fl_clr_frame;
        clr_vec[FLG_SYNC]  = fl_clr_sync;
        clr_vec[FLG_PAL]   = fl_clr_pal;
    end

    lcd_regif_flags flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_p    (set_vec),
        .clr_p    (clr_vec),
        .int_mask (int_mask_q),
        .flags    (flags),
        .irq      (irq)
    );

    // control register fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_mask_q  <= '0;
            mono_q      <= 1'b0;
            tft_q       <= 1'b0;
            plm_q       <= '0;
            ctrl_keep_q <= '0;
        end else if (wr_strobe[REG_CTRL]) begin
            int_mask_q  <= bus_wdata[4:3];
            mono_q      <= bus_wdata[1];
            tft_q       <= bus_wdata[7];
            plm_q       <= bus_wdata[21:20];
            ctrl_keep_q <= bus_wdata & CTRL_KEEP_MASK;
        end
    end

    // timing words, width and height stored as field plus one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim0_hi_q <= '0;
            width_q   <= '0;
        end else if (wr_strobe[REG_TIM0]) begin
            tim0_hi_q <= bus_wdata[DW-1:RES_W];
            width_q   <= {1'b0, bus_wdata[RES_W-1:0]} + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim1_hi_q <= '0;
            height_q  <= '0;
        end else if (wr_strobe[REG_TIM1]) begin
            tim1_hi_q <= bus_wdata[DW-1:RES_W];
            height_q  <= {1'b0, bus_wdata[RES_W-1:0]} + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim2_q <= '0;
        end else if (wr_strobe[REG_TIM2]) begin
            tim2_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            subp_q <= '0;
        end else if (wr_strobe[REG_SUBP]) begin
            subp_q <= bus_wdata & SUBP_MASK;
        end
    end

    assign width_m1  = width_q  - 1'b1;
    assign height_m1 = height_q - 1'b1;

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (region)
            REG_CTRL: begin
                bus_rdata        = CTRL_RD_ONES | ctrl_keep_q;
                bus_rdata[23]    = bus_rdata[23] | tft_q;
                bus_rdata[21:20] = bus_rdata[21:20] | plm_q;
                bus_rdata[7]     = bus_rdata[7] | tft_q;
                bus_rdata[4:3]   = bus_rdata[4:3] | int_mask_q;
                bus_rdata[1]     = bus_rdata[1] | mono_q;
                bus_rdata[0]     = bus_rdata[0] | cfg_enable;
            end
            REG_TIM0: bus_rdata = {tim0_hi_q, width_m1[RES_W-1:0]} | TIM0_RD_ONES;
            REG_TIM1: bus_rdata = {tim1_hi_q, height_m1[RES_W-1:0]};
            REG_TIM2: bus_rdata = tim2_q | TIM2_RD_ONES;
            REG_STAT: begin
                bus_rdata[STAT_FRAME_BIT] = flags[FLG_FRAME];
                bus_rdata[STAT_SYNC_BIT]  = flags[FLG_SYNC];
                bus_rdata[STAT_PAL_BIT]   = flags[FLG_PAL];
            end
            REG_SUBP: bus_rdata = subp_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign cfg_mono   = mono_q;
    assign cfg_tft    = tft_q;
    assign cfg_plm    = plm_q;
    assign cfg_width  = width_q;
    assign cfg_height = height_q;

endmodule

// File: rtl/lcd_regif_checker.sv
module lcd_regif_checker #(
    parameter int ADDR_W = 8,
    parameter int RES_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              fl_set_frame,
    input logic              fl_set_sync,
    input logic              fl_set_pal,
    input logic              fl_clr_frame,
    input logic              fl_clr_sync,
    input logic              fl_clr_pal,
    input logic              irq,
    input logic              seq_start,
    input logic              seq_stop,
    input logic              cfg_enable,
    input logic [RES_W:0]    cfg_width
);
    logic ctrl_wr, tim0_wr, stat_wr, seq_quiet;
    assign ctrl_wr   = bus_sel && bus_we && (bus_addr == ADDR_W'(0));
    assign tim0_wr   = bus_sel && bus_we && (bus_addr == ADDR_W'(4));
    assign stat_wr   = bus_sel && bus_we && (bus_addr == ADDR_W'(16));
    assign seq_quiet = !(fl_set_frame || fl_set_sync || fl_set_pal ||
                         fl_clr_frame || fl_clr_sync || fl_clr_pal);

    assert_sync_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fl_set_sync |=> irq);

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_start, seq_stop}));

    assert_start_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> cfg_enable);

    assert_stop_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_stop |-> !cfg_enable);

    assert_rise_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_enable) |-> seq_start);

    assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(cfg_enable));

    assert_stat_wr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && seq_quiet) |=> $stable(irq));

    assert_misaligned_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'h0));

    assert_width_plus_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tim0_wr |=> (cfg_width == ({1'b0, $past(bus_wdata[RES_W-1:0])} + 1'b1)));

endmodule

bind lcd_regif lcd_regif_checker #(.ADDR_W(ADDR_W), .RES_W(RES_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .fl_set_frame (fl_set_frame),
    .fl_set_sync  (fl_set_sync),
    .fl_set_pal   (fl_set_pal),
    .fl_clr_frame (fl_clr_frame),
    .fl_clr_sync  (fl_clr_sync),
    .fl_clr_pal   (fl_clr_pal),
    .irq          (irq),
    .seq_start    (seq_start),
    .seq_stop     (seq_stop),
    .cfg_enable   (cfg_enable),
    .cfg_width    (cfg_width)
);

// File: tb/lcd_regif_tb.sv
`timescale 1ns/1ps
module lcd_regif_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fl_set_frame = 0, fl_set_sync = 0, fl_set_pal = 0;
    logic        fl_clr_frame = 0, fl_clr_sync = 0, fl_clr_pal = 0;
    logic        irq, seq_start, seq_stop, cfg_enable, cfg_mono, cfg_tft;
    logic [1:0]  cfg_plm;
    logic [10:0] cfg_width, cfg_height;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    lcd_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fl_set_frame(fl_set_frame), .fl_set_sync(fl_set_sync), .fl_set_pal(fl_set_pal),
        .fl_clr_frame(fl_clr_frame), .fl_clr_sync(fl_clr_sync), .fl_clr_pal(fl_clr_pal),
        .irq(irq), .seq_start(seq_start), .seq_stop(seq_stop),
        .cfg_enable(cfg_enable), .cfg_mono(cfg_mono), .cfg_tft(cfg_tft),
        .cfg_plm(cfg_plm), .cfg_width(cfg_width), .cfg_height(cfg_height)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] rexp;
        logic [7:0]  req;
    } vec_t;

    // write, then read back the same offset
    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 32'h0010_009A, 32'hFE90_0CBE, 8'd2},   // R2 fields, enable 0
        '{8'h00, 32'hFFFF_FF7E, 32'hFFFF_FF3E, 8'd2},   // R2 keep mask, mask bits = 3
        '{8'h04, 32'h0000_1450, 32'h0000_145F, 8'd3},   // R3
        '{8'h08, 32'hABCD_E3FF, 32'hABCD_E3FF, 8'd4},   // R4
        '{8'h0C, 32'h0123_4567, 32'hFD23_4567, 8'd5},   // R5
        '{8'h14, 32'hFFFF_FFFF, 32'hA1FF_FFFF, 8'd6},   // R6
        '{8'h10, 32'hFFFF_FFFF, 32'h0000_0000, 8'd7},   // R7 write ignored
        '{8'h18, 32'hFFFF_FFFF, 32'h0000_0000, 8'd11},  // R11 index 6
        '{8'h02, 32'hFFFF_FFFF, 32'h0000_0000, 8'd11},  // R11 misaligned
        '{8'hFC, 32'hFFFF_FFFF, 32'h0000_0000, 8'd11}   // R11 high index
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input int which, input bit is_set);
        @(negedge clk);
        case (which)
            0: if (is_set) fl_set_frame = 1; else fl_clr_frame = 1;
            1: if (is_set) fl_set_sync  = 1; else fl_clr_sync  = 1;
            default: if (is_set) fl_set_pal = 1; else fl_clr_pal = 1;
        endcase
        @(negedge clk);
        {fl_set_frame, fl_set_sync, fl_set_pal, fl_clr_frame, fl_clr_sync, fl_clr_pal} = '0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h00, rd); check("R1 ctrl", rd, 32'hFE00_0C34);
        bus_read(8'h04, rd); check("R1 tim0", rd, 32'h0000_03FF);
        bus_read(8'h08, rd); check("R1 tim1", rd, 32'h0000_03FF);
        bus_read(8'h0C, rd); check("R1 tim2", rd, 32'hFC00_0000);
        bus_read(8'h10, rd); check("R1 stat", rd, 32'h0);
        bus_read(8'h14, rd); check("R1 subp", rd, 32'h0);
        check("R1 irq/en/width", {irq, cfg_enable, cfg_width, cfg_height}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            bus_write(VECS[i].addr, VECS[i].wdata);
            bus_read(VECS[i].addr, rd);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].rexp);
        end

        check("R3 width", {21'b0, cfg_width}, 32'h51);
        check("R4 height", {21'b0, cfg_height}, 32'h400);
        check("R2 cfg outs", {28'b0, cfg_mono, cfg_tft, cfg_plm}, 32'hB);
        // R11 unmapped writes left registers intact
        bus_read(8'h14, rd); check("R11 subp kept", rd, 32'hA1FF_FFFF);
        bus_read(8'h00, rd); check("R11 ctrl kept", rd, 32'hFFFF_FF3E);

        // R7 / R8 flags and masking (mask bits are 3 here)
        pulse(0, 1);
        bus_read(8'h10, rd); check("R7 frame set", rd, 32'h01);
        check("R8 irq frame", {31'b0, irq}, 32'h1);
        pulse(0, 0);
        bus_read(8'h10, rd); check("R7 frame clr", rd, 32'h0);
        check("R8 irq low", {31'b0, irq}, 32'h0);
        pulse(2, 1);
        bus_read(8'h10, rd); check("R7 pal set", rd, 32'h40);
        check("R8 irq pal", {31'b0, irq}, 32'h1);
        bus_write(8'h00, 32'h0);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        pulse(0, 1);
        check("R8 frame masked", {31'b0, irq}, 32'h0);
        pulse(1, 1);
        bus_read(8'h10, rd); check("R7 three set", rd, 32'h45);
        check("R9 sync unmasked", {31'b0, irq}, 32'h1);
        pulse(1, 0); pulse(2, 0); pulse(0, 0);
        bus_read(8'h10, rd); check("R7 all clr", rd, 32'h0);
        check("R9 irq low", {31'b0, irq}, 32'h0);
        // R7 set wins over clear in the same cycle
        @(negedge clk);
        fl_set_pal = 1; fl_clr_pal = 1;
        @(negedge clk);
        fl_set_pal = 0; fl_clr_pal = 0;
        bus_read(8'h10, rd); check("R7 set wins", rd, 32'h40);
        pulse(2, 0);

        // R10 start / stop pulses
        check("R10 idle", {30'b0, seq_start, seq_stop}, 32'h0);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = 8'h00; bus_wdata = 32'h1;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        check("R10 start pulse", {29'b0, seq_start, seq_stop, cfg_enable}, 32'h5);
        @(negedge clk);
        check("R10 start one cycle", {30'b0, seq_start, seq_stop}, 32'h0);
        bus_write(8'h00, 32'h1);
        check("R10 no pulse same value", {30'b0, seq_start, seq_stop}, 32'h0);
        bus_read(8'h00, rd); check("R10 enable read", rd, 32'hFE00_0C35);
        bus_write(8'h00, 32'h0);
        check("R10 stop pulse", {29'b0, seq_start, seq_stop, cfg_enable}, 32'h2);
        @(negedge clk);
        check("R10 stop one cycle", {30'b0, seq_start, seq_stop}, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule